// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Gating

This block turns bytes written by a host into asynchronous serial frames on a single output line. Characters enter an eight-entry queue and are sent one at a time. A frame opens with a low start bit and carries 5 to 8 data bits, least significant first. An optional parity bit follows, then one or two high stop bits. Bit timing comes from an external enable pulse at sixteen times the bit rate. The block does not divide its clock itself.

The host controls the block through a small command code. It can enable or disable the channel, reset it outright, and start or end a break. Two status outputs tell the host when it may write (`tx_rdy`) and when every queued character has fully left the line (`tx_emt`). An optional clear-to-send gate holds back the next character while the far end signals not-ready. The gate is consulted only when a character is about to start. Frame shape (character length, parity, stop bits) is taken from the mode inputs when each character begins.

Top module: `async_tx_core`

## Requirements
- R1: After `rst_n` is released, `txd` is high and `tx_rdy` and `tx_emt` are both low. The line stays high whenever nothing is being sent.
- R2: A frame is one low start bit, then `char_len`+5 data bits sent LSB first (code 0 gives 5 bits, code 3 gives 8), then the parity bit when `parity_en` is 1, then one high stop bit, or two when `two_stop` is 1.
- R3: With `parity_odd` = 0 the parity bit makes the count of ones over the data and parity bits even. With `parity_odd` = 1 it makes that count odd.
- R4: The enable command (code 1) issued while the channel is disabled raises both `tx_rdy` and `tx_emt`.
- R5: `tx_rdy` is high exactly when the channel is enabled and fewer than 8 characters are queued. The queue sends characters in write order, and a write made while it holds 8 characters is dropped.
- R6: An accepted write clears `tx_emt`. `tx_emt` sets again only in the cycle the last stop bit ends with the queue empty. If a write is accepted in that same cycle, `tx_emt` stays low.
- R7: The disable command (code 2) clears `tx_rdy` and `tx_emt`. The character in flight and all queued characters are still sent. Writes made while disabled are ignored, and `tx_emt` stays low after the queue drains.
- R8: The reset command (code 3) forces `txd` high in the next cycle and discards the queued characters. It clears both status outputs and leaves the channel disabled until an enable command.
- R9: The break command (code 4) holds `txd` low from the next cycle until the end-break command (code 5). No character starts while the break is active. Queued characters are sent after the break ends.
- R10: When `cts_gate` is 1 and `cts_n` is high, no new character starts. A character already started is sent unchanged even if `cts_n` rises during it.
- R11: Each bit lasts exactly 16 `baud_tick` pulses, however many clock cycles separate the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| cmd_code | input | 3 | Command: 0 none, 1 enable, 2 disable, 3 reset, 4 break on, 5 break off |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_gate | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send from the far end, active low |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Host may write a character |
| tx_emt | output | 1 | Queue and shifter both empty |

## Verification
Two events can land on the same clock edge: the last stop bit of a character ends, and the host writes a new character. The bench counts cycles from a write to the exact edge where the stop bit ends. It places a second write on that edge in one run and one edge later in another. With the coinciding write, `tx_emt` must never pulse high and the new character must still go out intact. With the late write, `tx_emt` must be high for the one cycle between the two edges and then fall. Frame contents are decoded from `txd` by a mid-bit sampler in the bench, for every combination of character length, parity mode and stop count.

// File: rtl/atx_pkg.sv
// Package: shared command encoding and timing constants for the serial
// transmitter. Assumes commands arrive as a single code per cycle.
package atx_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_ENABLE    = 3'd1,
        CMD_DISABLE   = 3'd2,
        CMD_RESET     = 3'd3,
        CMD_BREAK_ON  = 3'd4,
        CMD_BREAK_OFF = 3'd5
    } atx_cmd_e;

    localparam int unsigned ATX_OVERSAMPLE = 16;
endpackage

// File: rtl/atx_fifo.sv
// Module: character queue. Synchronous first-in first-out store.
// A push when full and a pop when empty are ignored. Flush empties the
// queue and has priority over push and pop.
module atx_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [CNTW-1:0]  count;
    logic             do_push;
    logic             do_pop;

    assign full     = (count == CNTW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign pop_data = mem[rp];

    // Store the pushed character in its slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            if (do_push && !do_pop) begin
                count <= count + CNTW'(1);
            end else if (do_pop && !do_push) begin
                count <= count - CNTW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH)); // R5
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count))); // R5
endmodule

// File: rtl/atx_shifter.sv
// Module: frame serializer. On load it builds the whole frame from the
// character and the mode inputs: start, data LSB first, optional parity,
// then stop bits. It shifts one bit per OVERSAMPLE ticks.
// Assumes load is only raised while not busy. Abort returns the line high.
module atx_shifter #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    output logic              busy,
    output logic              line,
    output logic              done
);
    localparam int unsigned FRAME_W = DATA_W + 4;
    localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
    localparam int unsigned CW      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int unsigned MIN_LEN = DATA_W - 3;

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame_next;
    logic [LEN_W-1:0]   len_next;
    logic [LEN_W-1:0]   n_data;
    logic [LEN_W-1:0]   left;
    logic [CW-1:0]      tcnt;
    logic               par;
    logic               bit_end;

    assign line    = shreg[0];
    assign bit_end = busy && tick && (tcnt == CW'(OVERSAMPLE - 1));
    assign done    = bit_end && (left == LEN_W'(1));

    // Assemble the complete frame and its length from the mode inputs.
    always_comb begin
        n_data     = LEN_W'(MIN_LEN) + LEN_W'(char_len);
        frame_next = '1;
        frame_next[0] = 1'b0;
        par = parity_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (LEN_W'(i) < n_data) begin
                frame_next[i + 1] = load_data[i];
                par = par ^ load_data[i];
            end
        end
        for (int i = 1; i < FRAME_W; i++) begin
            if (parity_en && (LEN_W'(i) == n_data + LEN_W'(1))) begin
                frame_next[i] = par;
            end
        end
        len_next = n_data + LEN_W'(2) + LEN_W'(parity_en) + LEN_W'(two_stop);
    end

    // Load, time and shift the frame one bit per OVERSAMPLE ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy  <= 1'b0;
            shreg <= '1;
            tcnt  <= '0;
            left  <= '0;
        end else if (load && !busy) begin
            busy  <= 1'b1;
            shreg <= frame_next;
            tcnt  <= '0;
            left  <= len_next;
        end else if (busy && tick) begin
            if (bit_end) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - LEN_W'(1);
                if (left == LEN_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                tcnt <= tcnt + CW'(1);
            end
        end
    end

    AST_LAST_BIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left == LEN_W'(1)) |-> line); // R2
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R2
endmodule

// File: rtl/async_tx_core.sv
// Module: transmit channel top. It joins the character queue and the
// serializer, decodes host commands, and keeps the enable, break and empty
// state. Assumes baud_tick is a single-cycle pulse at OVERSAMPLE times the
// bit rate, and that mode inputs are steady while a character starts.
module async_tx_core #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned OVERSAMPLE = atx_pkg::ATX_OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [2:0]        cmd_code,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              cts_gate,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt
);
    import atx_pkg::*;

    logic              enabled;
    logic              brk;
    logic              emt_q;
    logic              is_enable;
    logic              is_disable;
    logic              is_reset;
    logic              is_brk_on;
    logic              is_brk_off;
    logic              push_ok;
    logic              load;
    logic              cts_block;
    logic              empty;
    logic              full;
    logic              busy;
    logic              line;
    logic              done;
    logic [DATA_W-1:0] head;

    assign is_enable  = (cmd_code == CMD_ENABLE);
    assign is_disable = (cmd_code == CMD_DISABLE);
    assign is_reset   = (cmd_code == CMD_RESET);
    assign is_brk_on  = (cmd_code == CMD_BREAK_ON);
    assign is_brk_off = (cmd_code == CMD_BREAK_OFF);

    assign cts_block = cts_gate && cts_n;
    assign push_ok   = wr_en && enabled && !full && !is_reset;
    assign load      = !empty && !busy && !brk && !cts_block && !is_reset;

    atx_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (is_reset),
        .push      (push_ok),
        .push_data (wr_data),
        .pop       (load),
        .pop_data  (head),
        .empty     (empty),
        .full      (full)
    );

    atx_shifter #(
        .DATA_W     (DATA_W),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (is_reset),
        .tick       (baud_tick),
        .load       (load),
        .load_data  (head),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .busy       (busy),
        .line       (line),
        .done       (done)
    );

    // Track enable, break and empty status from commands, writes and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || is_reset) begin
            enabled <= 1'b0;
            brk     <= 1'b0;
            emt_q   <= 1'b0;
        end else begin
            if (is_brk_on) begin
                brk <= 1'b1;
            end else if (is_brk_off) begin
                brk <= 1'b0;
            end
            if (is_disable) begin
                enabled <= 1'b0;
                emt_q   <= 1'b0;
            end else if (is_enable) begin
                enabled <= 1'b1;
                if (!enabled) begin
                    emt_q <= 1'b1;
                end else if (push_ok) begin
                    emt_q <= 1'b0;
                end
            end else if (push_ok) begin
                emt_q <= 1'b0;
            end else if (done && empty && enabled) begin
                emt_q <= 1'b1;
            end
        end
    end

    assign txd    = brk ? 1'b0 : line;
    assign tx_rdy = enabled && !full;
    assign tx_emt = emt_q;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset |=> (txd && !tx_rdy && !tx_emt)); // R8
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_brk_on |=> !txd); // R9
    AST_CTS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cts_block)); // R10
    AST_EMT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_emt) && !$past(is_enable)) |-> (!busy && empty)); // R6
endmodule

// File: tb/async_tx_core_test.sv
// Bench: drives host writes and commands, decodes txd with a mid-bit
// sampler and compares against frames computed from the requirements.
module async_tx_core_test;
    import atx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] char_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       cts_gate = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       tx_rdy;
    logic       tx_emt;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int ph = 0;

    always #2 clk = ~clk;

    async_tx_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .cmd_code   (cmd_code),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .cts_gate   (cts_gate),
        .cts_n      (cts_n),
        .txd        (txd),
        .tx_rdy     (tx_rdy),
        .tx_emt     (tx_emt)
    );

    // Tick generator: one pulse every tick_div cycles.
    always @(negedge clk) begin
        baud_tick <= (ph == 0);
        ph <= (ph + 1 >= tick_div) ? 0 : ph + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic command(input atx_cmd_e c);
        @(negedge clk);
        cmd_code = c;
        @(negedge clk);
        cmd_code = CMD_NOP;
    endtask

    task automatic expect_level(input int n, input logic lvl,
                                input string req, input string what);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== lvl) bad++;
        end
        chk(req, what, bad, 0);
    endtask

    // Receive one frame and compare it with the expected frame for d.
    task automatic recv(input logic [7:0] d, input string req);
        int wait_n = 0;
        int bp = 16 * tick_div;
        int nd = 5 + int'(char_len);
        int ones = 0;
        logic [7:0] got = 8'h00;
        logic [7:0] m;
        logic [1:0] stops;
        logic pbit;
        logic exp_p;
        while (txd !== 1'b0 && wait_n < 6000) begin
            @(negedge clk);
            wait_n++;
        end
        if (txd !== 1'b0) begin
            chk(req, "start bit seen", 0, 1);
            return;
        end
        repeat (bp / 2) @(negedge clk);
        chk(req, "start bit low", txd, 0);
        for (int i = 0; i < nd; i++) begin
            repeat (bp) @(negedge clk);
            got[i] = txd;
        end
        m = d & 8'((1 << nd) - 1);
        chk(req, "data bits LSB first", got, m);
        if (parity_en) begin
            repeat (bp) @(negedge clk);
            pbit = txd;
            for (int i = 0; i < 8; i++) ones += int'(m[i]);
            exp_p = ((ones % 2) == 1) ^ parity_odd;
            chk("R3", "parity bit", pbit, exp_p);
        end
        repeat (bp) @(negedge clk);
        stops[0] = txd;
        stops[1] = 1'b1;
        if (two_stop) begin
            repeat (bp) @(negedge clk);
            stops[1] = txd;
        end
        chk(req, "stop bits high", stops, 2'b11);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int idx = 0;
        logic [7:0] q [8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "txd after reset", txd, 1);
        chk("R1", "tx_rdy after reset", tx_rdy, 0);
        chk("R1", "tx_emt after reset", tx_emt, 0);

        // Writes before any enable are ignored.
        write_char(8'h3C);
        expect_level(40, 1'b1, "R7", "no frame while disabled");

        command(CMD_ENABLE);
        chk("R4", "tx_rdy on enable", tx_rdy, 1);
        chk("R4", "tx_emt on enable", tx_emt, 1);

        // Sweep every frame shape.
        for (int cl = 0; cl < 4; cl++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    logic [7:0] d;
                    char_len = 2'(cl);
                    parity_en = (pm != 0);
                    parity_odd = (pm == 2);
                    two_stop = st[0];
                    d = 8'(37 * idx + 91);
                    idx++;
                    write_char(d);
                    chk("R6", "tx_emt cleared by write", tx_emt, 0);
                    recv(d, "R2");
                    repeat (8 + 2) @(negedge clk);
                    chk("R6", "tx_emt after last stop", tx_emt, 1);
                end
            end
        end

        // Collision: write lands on the edge that ends the last stop bit.
        char_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        write_char(8'h81);
        repeat (160) @(negedge clk);
        chk("R6", "tx_emt before coinciding write", tx_emt, 0);
        wr_en = 1'b1; wr_data = 8'h7E;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", "tx_emt held low by coinciding write", tx_emt, 0);
        recv(8'h7E, "R6");
        repeat (10) @(negedge clk);
        chk("R6", "tx_emt after second frame", tx_emt, 1);
        write_char(8'h55);
        repeat (161) @(negedge clk);
        chk("R6", "tx_emt one cycle after stop end", tx_emt, 1);
        wr_en = 1'b1; wr_data = 8'h12;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", "tx_emt cleared by late write", tx_emt, 0);
        recv(8'h12, "R6");
        repeat (10) @(negedge clk);

        // Fill the queue while CTS holds it back.
        cts_gate = 1'b1; cts_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            q[i] = 8'(8'hC3 ^ (i * 29));
            write_char(q[i]);
            chk("R5", "tx_rdy while filling", tx_rdy, (i < 7) ? 1 : 0);
        end
        write_char(8'hEE);
        expect_level(200, 1'b1, "R10", "line idle while CTS high");
        cts_n = 1'b0;
        for (int i = 0; i < 8; i++) recv(q[i], "R5");
        expect_level(60, 1'b1, "R5", "write to full queue dropped");
        chk("R6", "tx_emt after queue drains", tx_emt, 1);

        // CTS rising mid-character does not disturb it; next one waits.
        write_char(8'hA6);
        write_char(8'h4B);
        fork
            recv(8'hA6, "R10");
            begin
                repeat (40) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        expect_level(300, 1'b1, "R10", "next char held by CTS");
        cts_n = 1'b0;
        recv(8'h4B, "R10");
        cts_gate = 1'b0;
        repeat (10) @(negedge clk);

        // Disable drains queued characters and blocks new writes.
        fork
            begin
                recv(8'h11, "R7");
                recv(8'h22, "R7");
                recv(8'h33, "R7");
            end
            begin
                write_char(8'h11);
                write_char(8'h22);
                write_char(8'h33);
                command(CMD_DISABLE);
                chk("R7", "tx_rdy after disable", tx_rdy, 0);
                chk("R7", "tx_emt after disable", tx_emt, 0);
                write_char(8'h44);
            end
        join
        expect_level(60, 1'b1, "R7", "write while disabled ignored");
        chk("R7", "tx_emt stays low after drain", tx_emt, 0);
        command(CMD_ENABLE);
        chk("R4", "tx_emt on re-enable", tx_emt, 1);
        chk("R4", "tx_rdy on re-enable", tx_rdy, 1);

        // Reset aborts at once and discards the queue.
        write_char(8'h99);
        write_char(8'h66);
        repeat (30) @(negedge clk);
        command(CMD_RESET);
        chk("R8", "txd high after reset cmd", txd, 1);
        chk("R8", "tx_rdy after reset cmd", tx_rdy, 0);
        chk("R8", "tx_emt after reset cmd", tx_emt, 0);
        write_char(8'h77);
        expect_level(500, 1'b1, "R8", "no output after reset");
        command(CMD_ENABLE);
        chk("R8", "tx_rdy needs enable", tx_rdy, 1);
        write_char(8'h5A);
        recv(8'h5A, "R8");
        repeat (10) @(negedge clk);

        // Break holds the line low and defers queued characters.
        command(CMD_BREAK_ON);
        chk("R9", "txd low on break", txd, 0);
        write_char(8'hB4);
        expect_level(300, 1'b0, "R9", "line low during break");
        command(CMD_BREAK_OFF);
        chk("R9", "txd high after break off", txd, 1);
        recv(8'hB4, "R9");
        repeat (10) @(negedge clk);

        // Slower tick: bit length follows ticks, not clocks.
        tick_div = 3;
        repeat (6) @(negedge clk);
        char_len = 2'd2; parity_en = 1'b1; parity_odd = 1'b0; two_stop = 1'b1;
        write_char(8'h6D);
        recv(8'h6D, "R11");
        repeat (40) @(negedge clk);
        chk("R11", "tx_emt after slow frame", tx_emt, 1);

        finish_run();
    end
endmodule